// File: doc/BRIEF.md
# Program and Emulation Exception Classifier

This block sits after instruction decode and decides which exception, if any, a decoded instruction raises. Each cycle with the valid strobe high, it takes the instruction's class flags, the special-register field and its two attribute flags, and the machine state bits. One cycle later it presents a 2-bit exception code. The code says no exception, a privileged-instruction program exception, or a software-emulation exception.

Illegal opcodes and all floating-point instructions go to the emulation exception. They never raise the usual illegal-instruction or floating-point-unavailable program exceptions. A floating-point-enabled program exception is never produced. Privilege faults come from privileged instructions run in user (problem) state. They also come from special-register moves in user state when the register is implemented on the core or is encoded as external and the field's most significant bit is set.

Top module: `exc_classifier`

## Requirements
- R1: While reset is low, and on the first cycle after reset, `exc_code_o` is 2'b00 (none).
- R2: A valid instruction with `is_illegal_i` = 1 gives `exc_code_o` = 2'b10 (emulation) on the cycle after the strobe.
- R3: A valid instruction with `is_fp_i` = 1 gives 2'b10 on the next cycle, whether `fp_avail_i` is 0 or 1.
- R4: A valid instruction with `is_priv_i` = 1 and `user_mode_i` = 1, and neither emulation flag set, gives 2'b01 (privileged) on the next cycle.
- R5: A valid special-register move (`is_spr_i` = 1) gives 2'b01 on the next cycle when all of these hold: `spr_field_i` bit SPR_W-1 is 1, `user_mode_i` = 1, and `spr_oncore_i` or `spr_external_i` is 1. Neither emulation flag may be set.
- R6: A special-register move with field bit SPR_W-1 at 0, or with both `spr_oncore_i` and `spr_external_i` at 0, raises no exception on its own. The code is 2'b00 unless another rule applies.
- R7: With `user_mode_i` = 0, the privileged-instruction and special-register checks never raise an exception.
- R8: When an emulation condition and a privilege condition both hold, the code is 2'b10.
- R9: On the cycle after `valid_i` is low, the code is 2'b00, whatever the other inputs are.
- R10: The code value 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Decoded instruction present this cycle |
| is_illegal_i | input | 1 | Opcode is not a defined instruction |
| is_fp_i | input | 1 | Instruction is a floating-point operation |
| is_priv_i | input | 1 | Instruction is privileged |
| is_spr_i | input | 1 | Instruction moves to or from a special register |
| spr_field_i | input | SPR_W | Special-register number field; bit SPR_W-1 marks a supervisor register |
| spr_oncore_i | input | 1 | Register number is implemented on the core |
| spr_external_i | input | 1 | Register number is encoded as an external register |
| user_mode_i | input | 1 | Problem state: 1 = user, 0 = supervisor |
| fp_avail_i | input | 1 | Floating-point available bit; has no effect on the result |
| exc_code_o | output | 2 | Registered code: 00 none, 01 privileged, 10 emulation |

## Verification
The checker watches every cycle for these rules: each emulation condition leads to 2'b10 on the next edge, each user-state privilege condition without an emulation flag leads to 2'b01, and supervisor state or an idle strobe leads to 2'b00. It also watches that 2'b11 never appears. Some facts need chosen stimulus rather than a per-cycle rule. One is that `fp_avail_i` truly has no effect. Another is that special-register moves with the low bit or without either attribute flag stay silent. A third is that every lower field bit is ignored. The bench sweeps every combination of flags and state bits with both strobe values to show these.

// File: rtl/exc_classifier.sv
// Shared encodings for the exception classifier.
package exc_pkg;
    typedef enum logic [1:0] {
        EXC_NONE = 2'b00,
        EXC_PRIV = 2'b01,
        EXC_EMUL = 2'b10
    } exc_code_e;
endpackage

// exc_emul_detect: flags instructions that must be handed to the
// software-emulation handler. Assumes the decode flags are stable while
// valid. The floating-point available bit is accepted but deliberately
// has no influence: every floating-point op is emulated.
module exc_emul_detect (
    input  logic is_illegal_i,
    input  logic is_fp_i,
    input  logic fp_avail_i,
    output logic emul_o
);
    logic fp_avail_unused;
    assign fp_avail_unused = fp_avail_i;

    // Emulation is needed for undefined opcodes and for any FP operation.
    always_comb emul_o = is_illegal_i | is_fp_i;
endmodule

// exc_priv_detect: flags privilege violations raised in user state.
// Assumes bit SPR_W-1 of the register field marks supervisor-only
// registers; the lower field bits play no part in the decision.
module exc_priv_detect #(
    parameter int SPR_W = 10
) (
    input  logic             is_priv_i,
    input  logic             is_spr_i,
    input  logic [SPR_W-1:0] spr_field_i,
    input  logic             spr_oncore_i,
    input  logic             spr_external_i,
    input  logic             user_mode_i,
    output logic             priv_o
);
    localparam int SUP_BIT = SPR_W - 1;

    logic spr_low_unused;
    logic spr_hit;
    generate
        if (SPR_W > 1) begin : g_low
            assign spr_low_unused = ^spr_field_i[SUP_BIT-1:0];
        end else begin : g_nolow
            assign spr_low_unused = 1'b0;
        end
    endgenerate

    // A register move faults if the target is recognised and supervisor-only.
    always_comb spr_hit = is_spr_i & (spr_oncore_i | spr_external_i)
                          & spr_field_i[SUP_BIT];

    // Only user state can produce a privilege violation.
    always_comb priv_o = user_mode_i & (is_priv_i | spr_hit);
endmodule

// exc_code_reg: resolves priority and registers the exception code.
// Emulation wins over privilege; an idle strobe registers "none".
module exc_code_reg (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             emul_i,
    input  logic             priv_i,
    output exc_pkg::exc_code_e code_o
);
    import exc_pkg::*;
    exc_code_e code_nxt;

    // Pick the winning exception for the current instruction.
    always_comb begin
        if (!valid_i)    code_nxt = EXC_NONE;
        else if (emul_i) code_nxt = EXC_EMUL;
        else if (priv_i) code_nxt = EXC_PRIV;
        else             code_nxt = EXC_NONE;
    end

    // Hold the result for one cycle; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) code_o <= EXC_NONE;
        else        code_o <= code_nxt;
    end
endmodule

// exc_classifier: top level. Classifies each strobed instruction into
// none / privileged / emulation with one cycle of latency.
module exc_classifier #(
    parameter int SPR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             is_illegal_i,
    input  logic             is_fp_i,
    input  logic             is_priv_i,
    input  logic             is_spr_i,
    input  logic [SPR_W-1:0] spr_field_i,
    input  logic             spr_oncore_i,
    input  logic             spr_external_i,
    input  logic             user_mode_i,
    input  logic             fp_avail_i,
    output logic [1:0]       exc_code_o
);
    logic emul;
    logic priv;
    exc_pkg::exc_code_e code;

    exc_emul_detect u_emul (
        .is_illegal_i (is_illegal_i),
        .is_fp_i      (is_fp_i),
        .fp_avail_i   (fp_avail_i),
        .emul_o       (emul)
    );

    exc_priv_detect #(.SPR_W(SPR_W)) u_priv (
        .is_priv_i      (is_priv_i),
        .is_spr_i       (is_spr_i),
        .spr_field_i    (spr_field_i),
        .spr_oncore_i   (spr_oncore_i),
        .spr_external_i (spr_external_i),
        .user_mode_i    (user_mode_i),
        .priv_o         (priv)
    );

    exc_code_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .emul_i  (emul),
        .priv_i  (priv),
        .code_o  (code)
    );

    // Present the enum as a plain vector at the port.
    assign exc_code_o = code;
endmodule

// File: rtl/exc_classifier_chk.sv
// exc_classifier_chk: per-cycle rules for the classifier, relating the
// inputs at one edge to the registered code at the next.
module exc_classifier_chk #(
    parameter int SPR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic             is_illegal_i,
    input logic             is_fp_i,
    input logic             is_priv_i,
    input logic             is_spr_i,
    input logic [SPR_W-1:0] spr_field_i,
    input logic             spr_oncore_i,
    input logic             spr_external_i,
    input logic             user_mode_i,
    input logic [1:0]       exc_code_o
);
    p_reset_none_r1: assert property (@(posedge clk)
        !rst_n |=> exc_code_o == 2'b00);

    p_illegal_emul_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_illegal_i) |=> exc_code_o == 2'b10);

    p_fp_emul_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_fp_i) |=> exc_code_o == 2'b10);

    p_priv_instr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_priv_i && user_mode_i && !is_illegal_i && !is_fp_i)
        |=> exc_code_o == 2'b01);

    p_spr_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_spr_i && user_mode_i && spr_field_i[SPR_W-1]
         && (spr_oncore_i || spr_external_i) && !is_illegal_i && !is_fp_i)
        |=> exc_code_o == 2'b01);

    p_supervisor_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !user_mode_i && !is_illegal_i && !is_fp_i)
        |=> exc_code_o == 2'b00);

    p_emul_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (is_illegal_i || is_fp_i) && user_mode_i && is_priv_i)
        |=> exc_code_o == 2'b10);

    p_idle_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> exc_code_o == 2'b00);

    p_no_code3_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_code_o != 2'b11);
endmodule

bind exc_classifier exc_classifier_chk #(.SPR_W(SPR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid_i        (valid_i),
    .is_illegal_i   (is_illegal_i),
    .is_fp_i        (is_fp_i),
    .is_priv_i      (is_priv_i),
    .is_spr_i       (is_spr_i),
    .spr_field_i    (spr_field_i),
    .spr_oncore_i   (spr_oncore_i),
    .spr_external_i (spr_external_i),
    .user_mode_i    (user_mode_i),
    .exc_code_o     (exc_code_o)
);

// File: tb/exc_classifier_tb.sv
module exc_classifier_tb;
    localparam int SPR_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0, is_illegal_i = 1'b0, is_fp_i = 1'b0, is_priv_i = 1'b0;
    logic is_spr_i = 1'b0, spr_oncore_i = 1'b0, spr_external_i = 1'b0;
    logic user_mode_i = 1'b0, fp_avail_i = 1'b0;
    logic [SPR_W-1:0] spr_field_i = '0;
    logic [1:0] exc_code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    exc_classifier #(.SPR_W(SPR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .is_illegal_i(is_illegal_i), .is_fp_i(is_fp_i), .is_priv_i(is_priv_i),
        .is_spr_i(is_spr_i), .spr_field_i(spr_field_i),
        .spr_oncore_i(spr_oncore_i), .spr_external_i(spr_external_i),
        .user_mode_i(user_mode_i), .fp_avail_i(fp_avail_i),
        .exc_code_o(exc_code_o)
    );

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (exc_code_o !== exp) begin
            fails++;
            $display("FAIL %s: exc_code_o=%b expected=%b (vec v=%b il=%b fp=%b pr=%b spr=%b msb=%b oc=%b ex=%b um=%b fa=%b)",
                     req, exc_code_o, exp, valid_i, is_illegal_i, is_fp_i,
                     is_priv_i, is_spr_i, spr_field_i[SPR_W-1], spr_oncore_i,
                     spr_external_i, user_mode_i, fp_avail_i);
        end
    endtask

    initial begin
        // Watchdog: a hung run counts as a failure and still reports.
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: code is none during reset.
        repeat (3) @(negedge clk);
        check("R1", 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 2'b00);

        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 1024; v++) begin
                logic il, fp, pv, sp, msb, oc, ex, um, fa, vl;
                logic emul, priv;
                logic [1:0] exp;
                string req;
                vl  = v[9]; il = v[0]; fp = v[1]; pv = v[2]; sp = v[3];
                msb = v[4]; oc = v[5]; ex = v[6]; um = v[7]; fa = v[8];
                valid_i = vl; is_illegal_i = il; is_fp_i = fp; is_priv_i = pv;
                is_spr_i = sp; spr_oncore_i = oc; spr_external_i = ex;
                user_mode_i = um; fp_avail_i = fa;
                // Lower field bits vary between passes and must not matter.
                spr_field_i = {msb, (pass == 0) ? (SPR_W-1)'(v * 37) : {(SPR_W-1){1'b1}}};
                emul = il | fp;
                priv = um & (pv | (sp & msb & (oc | ex)));
                if (!vl)       begin exp = 2'b00; req = "R9"; end
                else if (emul) begin
                    exp = 2'b10;
                    req = priv ? "R8" : (il ? "R2" : "R3");
                end
                else if (priv) begin exp = 2'b01; req = (pv ? "R4" : "R5"); end
                else begin
                    exp = 2'b00;
                    req = !um ? "R7" : "R6";
                end
                @(negedge clk);
                check(req, exp);
                checks++;
                if (exc_code_o === 2'b11) begin
                    fails++;
                    $display("FAIL R10: exc_code_o=11 expected=not 11");
                end
            end
        end

        // R1: reset asserted mid-stream clears a pending emulation code.
        valid_i = 1'b1; is_illegal_i = 1'b1;
        @(negedge clk);
        check("R2", 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 2'b00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule